// File: doc/BRIEF.md
# Direct-Mapped Read Cache Controller

This block sits between a processor load port and a slow backing memory and serves word reads from a small direct-mapped store. Every byte address is cut into three fields. The low bits give the byte position inside a line. The next bits pick the single line that may hold the block. The remaining high bits are compared against the tag kept for that line. A line counts as present only when its valid flag is set and its stored tag equals the address tag.

Once a request is accepted, the requester is held stalled until the response arrives. The controller spends a fixed number of cycles on the tag check. On a hit it spends a fixed number of cycles reading the word from the data store, then returns it. On a miss it issues one burst read for the line-aligned address and writes the returned words into the line in ascending order. It then updates the tag and valid flag, reads the requested word through the same data-store path and returns it. The backing memory takes a long time to deliver the first word of a burst and less time for each following word. Two counters record completed hits and misses, so the hit rate on a known trace can be measured.

Top module: `dm_read_cache`

## Requirements
- R1: With the default geometry (32-bit address, 16 lines of 64 bytes, 32-bit words), address bits [5:0] are the byte offset, bits [5:2] select the word in the line, bits [9:6] select the line and bits [31:10] form the tag. Two addresses whose bits [9:6] differ occupy different lines and never evict each other.
- R2: After reset, stall, rsp_valid and mem_req are 0, both counters are 0 and every line is invalid, so the first access to any block is a miss.
- R3: A hit raises rsp_valid exactly LOOKUP_CYC+READ_CYC (default 2+3=5) cycles after the accepting clock edge, returns the stored word and issues no memory request.
- R4: On a miss, mem_req is a single-cycle pulse whose mem_addr is the request address with bits [5:0] cleared. The response arrives LOOKUP_CYC+1 cycles plus the memory's burst time plus READ_CYC cycles after acceptance and carries the requested word of the refilled line.
- R5: A request is accepted only while stall is low. Stall is high in every cycle from the accepting edge until the response cycle, and it is low in the cycle where rsp_valid is high. A request presented while stall is high is ignored: it produces no response, no memory request and no counter change.
- R6: Each completed access increments exactly one counter: hit_count for a hit, miss_count for a miss.
- R7: A miss overwrites the indexed line with the new tag and data, so an earlier block with the same line index but a different tag misses on its next reference.
- R8: rsp_valid is high for exactly one cycle per accepted request.
- R9: After a refill, every other word of the same line hits and returns the word that memory supplied for its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Byte address of the load |
| stall | output | 1 | Requester must hold; high from acceptance until response |
| rsp_valid | output | 1 | One-cycle pulse with the returned word |
| rsp_data | output | WORD_W | Returned word |
| mem_req | output | 1 | One-cycle burst read request to backing memory |
| mem_addr | output | ADDR_W | Line-aligned burst start address |
| mem_word_valid | input | 1 | Strobe for one returned burst word |
| mem_word | input | WORD_W | Returned burst word, ascending order |
| hit_count | output | CNT_W | Completed hits |
| miss_count | output | CNT_W | Completed misses |

## Verification
The hardest case to reach from the ports is a conflict eviction. Two different blocks must land on the same line, and the first must then be shown to be gone. The stimulus fills one line, adds exactly the line-count times the line size to the address so that only the tag changes, and then returns to the first address. The bench expects a second miss on that address, with the full burst latency and fresh burst data. A second hard case is a request driven while a hit is still in flight. The bench raises req_valid partway through the stall window and then checks that no extra response, burst or count appears afterwards.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_MREQ   = 3'd2,
        ST_FILL   = 3'd3,
        ST_READ   = 3'd4
    } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 6,
    parameter int IDX_W      = 4,
    parameter int WORD_OFF_W = 2,
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int WSEL_W    = OFF_W - WORD_OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [WSEL_W-1:0] wsel
);
    // high bits -> tag, middle -> line, low -> word within line
    assign tag  = addr[ADDR_W-1 -: TAG_W];
    assign idx  = addr[OFF_W +: IDX_W];
    assign wsel = addr[WORD_OFF_W +: WSEL_W];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 22,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_mem [LINES];

    // one valid flag per line, cleared by reset; tags need no reset
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 16,
    parameter int WORD_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int DEPTH  = LINES * WORDS
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_idx, wr_wsel}] <= wr_data;
        end
    end

    assign rd_data = mem[{rd_idx, rd_wsel}];
endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINES      = 16,
    parameter int LINE_BYTES = 64,
    parameter int LOOKUP_CYC = 2,
    parameter int READ_CYC   = 3,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              stall,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_word_valid,
    input  logic [WORD_W-1:0] mem_word,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    import dmc_pkg::*;

    localparam int WORD_BYTES = WORD_W / 8;
    localparam int WORD_OFF_W = $clog2(WORD_BYTES);
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int WSEL_W     = $clog2(WORDS);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(LINES);
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
    localparam int WCNT_W     = $clog2(LOOKUP_CYC + READ_CYC + 1);

    typedef struct packed {
        dmc_state_e         st;
        logic [ADDR_W-1:0]  addr;
        logic [WCNT_W-1:0]  wcnt;
        logic [WSEL_W-1:0]  fill_ptr;
        logic               was_miss;
        logic               mem_req;
        logic               rsp_valid;
        logic [WORD_W-1:0]  rsp_data;
        logic [CNT_W-1:0]   hits;
        logic [CNT_W-1:0]   misses;
    } regs_t;

    regs_t r_q, r_d;

    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_wsel;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic              tag_wr_d;
    logic              data_wr_d;
    logic [WORD_W-1:0] rd_word;
    logic              is_hit;

    dmc_addr_split #(
        .ADDR_W     (ADDR_W),
        .OFF_W      (OFF_W),
        .IDX_W      (IDX_W),
        .WORD_OFF_W (WORD_OFF_W)
    ) u_split (
        .addr (r_q.addr),
        .tag  (a_tag),
        .idx  (a_idx),
        .wsel (a_wsel)
    );

    dmc_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (a_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .wr_en    (tag_wr_d),
        .wr_idx   (a_idx),
        .wr_tag   (a_tag)
    );

    dmc_data_store #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .WORD_W (WORD_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (data_wr_d),
        .wr_idx  (a_idx),
        .wr_wsel (r_q.fill_ptr),
        .wr_data (mem_word),
        .rd_idx  (a_idx),
        .rd_wsel (a_wsel),
        .rd_data (rd_word)
    );

    assign is_hit = line_valid && (line_tag == a_tag);

    always_comb begin
        r_d          = r_q;
        r_d.mem_req  = 1'b0;
        r_d.rsp_valid = 1'b0;
        tag_wr_d     = 1'b0;
        data_wr_d    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.wcnt = '0;
                    r_d.st   = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (r_q.wcnt == WCNT_W'(LOOKUP_CYC - 1)) begin
                    r_d.wcnt = '0;
                    if (is_hit) begin
                        r_d.was_miss = 1'b0;
                        r_d.st       = ST_READ;
                    end else begin
                        r_d.was_miss = 1'b1;
                        r_d.mem_req  = 1'b1;
                        r_d.st       = ST_MREQ;
                    end
                end else begin
                    r_d.wcnt = r_q.wcnt + 1'b1;
                end
            end
            ST_MREQ: begin
                r_d.fill_ptr = '0;
                r_d.st       = ST_FILL;
            end
            ST_FILL: begin
                if (mem_word_valid) begin
                    data_wr_d = 1'b1;
                    if (r_q.fill_ptr == WSEL_W'(WORDS - 1)) begin
                        tag_wr_d = 1'b1;
                        r_d.wcnt = '0;
                        r_d.st   = ST_READ;
                    end else begin
                        r_d.fill_ptr = r_q.fill_ptr + 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (r_q.wcnt == WCNT_W'(READ_CYC - 1)) begin
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_data  = rd_word;
                    r_d.st        = ST_IDLE;
                    if (r_q.was_miss) begin
                        r_d.misses = r_q.misses + 1'b1;
                    end else begin
                        r_d.hits = r_q.hits + 1'b1;
                    end
                end else begin
                    r_d.wcnt = r_q.wcnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign stall      = (r_q.st != ST_IDLE);
    assign rsp_valid  = r_q.rsp_valid;
    assign rsp_data   = r_q.rsp_data;
    assign mem_req    = r_q.mem_req;
    assign mem_addr   = {r_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign hit_count  = r_q.hits;
    assign miss_count = r_q.misses;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int CNT_W      = 32,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              stall,
    input logic              rsp_valid,
    input logic [WORD_W-1:0] rsp_data,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_word_valid,
    input logic [WORD_W-1:0] mem_word,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);
    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_unstalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !stall);

    assert_accept_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stall) |=> stall);

    assert_memreq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_memreq_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    assert_memreq_in_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> stall);

    assert_one_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (hit_count + miss_count == $past(hit_count) + $past(miss_count) + 1'b1));

    assert_count_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($stable(hit_count) && $stable(miss_count)));
endmodule

bind dm_read_cache dmc_checker #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_BYTES (LINE_BYTES),
    .CNT_W      (CNT_W)
) u_dmc_checker (.*);

// File: tb/tb_dm_read_cache.sv
module tb_dm_read_cache;
    localparam int CLK_PERIOD = 10;
    localparam int FIRST_CYC  = 50;
    localparam int NEXT_CYC   = 3;
    localparam int WORDS      = 16;
    localparam int HIT_LAT    = 2 + 3;
    localparam int MISS_LAT   = 2 + 1 + FIRST_CYC + NEXT_CYC * (WORDS - 1) + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        stall, rsp_valid, mem_req;
    logic [31:0] rsp_data, mem_addr;
    logic        mem_word_valid = 1'b0;
    logic [31:0] mem_word = '0;
    logic [31:0] hit_count, miss_count;

    int total = 0;
    int bad = 0;
    int burst_cnt = 0;
    logic [31:0] last_burst_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dm_read_cache dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .stall(stall), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_word_valid(mem_word_valid), .mem_word(mem_word),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return {w[15:0] ^ 16'h5a3c, w[31:16] ^ 16'h0ff1};
    endfunction

    // backing memory: first word slow, later words cheaper
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                logic [31:0] base;
                base = mem_addr;
                last_burst_addr = mem_addr;
                burst_cnt++;
                for (int i = 0; i < WORDS; i++) begin
                    repeat (i == 0 ? FIRST_CYC : NEXT_CYC - 1) @(negedge clk);
                    mem_word_valid = 1'b1;
                    mem_word = mem_val(base + 32'(4 * i));
                    @(negedge clk);
                    mem_word_valid = 1'b0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, output logic [31:0] data, output int lat);
        bit stall_ok;
        stall_ok = 1'b1;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 1000) begin
            if (!stall) stall_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        data = rsp_data;
        chk(stall_ok && !stall, "R5 stall window", 32'(stall), 32'(0));
        @(negedge clk);
        chk(!rsp_valid, "R8 single pulse", 32'(rsp_valid), 32'(0));
    endtask

    task automatic do_miss(input logic [31:0] a, input string req);
        logic [31:0] d; int lat; int b0;
        b0 = burst_cnt;
        access(a, d, lat);
        chk(d == mem_val(a), {req, " miss data"}, d, mem_val(a));
        chk(lat == MISS_LAT, {req, " miss latency"}, 32'(lat), 32'(MISS_LAT));
        chk(burst_cnt == b0 + 1, {req, " one burst"}, 32'(burst_cnt - b0), 32'(1));
        chk(last_burst_addr == {a[31:6], 6'b0}, "R4 burst address aligned", last_burst_addr, {a[31:6], 6'b0});
    endtask

    task automatic do_hit(input logic [31:0] a, input string req);
        logic [31:0] d; int lat; int b0;
        b0 = burst_cnt;
        access(a, d, lat);
        chk(d == mem_val(a), {req, " hit data"}, d, mem_val(a));
        chk(lat == HIT_LAT, {req, " hit latency R3"}, 32'(lat), 32'(HIT_LAT));
        chk(burst_cnt == b0, {req, " no burst on hit"}, 32'(burst_cnt - b0), 32'(0));
    endtask

    task automatic t_reset();
        chk(!stall && !rsp_valid && !mem_req, "R2 reset outputs", {29'b0, stall, rsp_valid, mem_req}, 32'(0));
        chk(hit_count == 0 && miss_count == 0, "R2 reset counters", hit_count + miss_count, 32'(0));
    endtask

    task automatic t_cold_and_line();
        do_miss(32'h1000_0044, "R2 cold");
        chk(miss_count == 1, "R6 miss counted", miss_count, 32'(1));
        do_hit(32'h1000_0040, "R9 same line first word");
        do_hit(32'h1000_007c, "R9 same line last word");
        do_hit(32'h1000_0046, "R3 byte address in word");
        chk(hit_count == 3, "R6 hits counted", hit_count, 32'(3));
    endtask

    task automatic t_conflict();
        // same bits [9:6], different tag
        do_miss(32'h1000_0444, "R7 conflicting tag");
        do_miss(32'h1000_0048, "R7 evicted block");
    endtask

    task automatic t_index_split();
        do_miss(32'h1000_0084, "R1 neighbour line");
        do_hit(32'h1000_0050, "R1 first line kept");
        do_hit(32'h1000_00b8, "R1 neighbour line kept");
    endtask

    task automatic t_busy_ignore();
        logic [31:0] h0, m0; int b0;
        bit extra;
        h0 = hit_count; m0 = miss_count; b0 = burst_cnt;
        extra = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 32'h1000_0058;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        // present a would-be miss while stalled
        req_valid = 1'b1;
        req_addr  = 32'h2000_0300;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk(rsp_data == mem_val(32'h1000_0058), "R5 in-flight response intact", rsp_data, mem_val(32'h1000_0058));
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rsp_valid || stall) extra = 1'b1;
        end
        chk(!extra, "R5 busy request ignored", 32'(extra), 32'(0));
        chk(burst_cnt == b0, "R5 no burst from ignored request", 32'(burst_cnt - b0), 32'(0));
        chk(hit_count == h0 + 1 && miss_count == m0, "R6 counters after ignore", hit_count - h0, 32'(1));
    endtask

    task automatic t_final_counts();
        chk(hit_count == 6, "R6 final hits", hit_count, 32'(6));
        chk(miss_count == 4, "R6 final misses", miss_count, 32'(4));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'(0), 32'(1));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_and_line();
        t_conflict();
        t_index_split();
        t_busy_ignore();
        t_final_counts();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule